// File: doc/BRIEF.md
# PLL Power-Up Initialization Sequencer

This block is the control state machine that carries a clock synthesizer from reset to running outputs. It sits in the control clock domain. It watches a power-on-reset flag, an active-low power-down input, an active-low reset pin and a register reset bit. It also watches a crystal swing-good flag. It receives one-cycle tick enables that stand for edges of the reference (phase-detector input) clock and of the feedback clock.

After release, the sequencer waits in three stages:
- a settling window counted in reference ticks;
- a second settling window counted in feedback ticks;
- a VCO calibration window counted in reference ticks, during which the calibration-active strobe is high.

The global output enable turns on in the same cycle that calibration ends. A lock flag follows after a further fixed number of reference ticks. Any reset or power-down throws the sequence back to its start with every output low.

All stage lengths are parameters. The defaults are 65536 reference ticks, 65536 feedback ticks, 131072 calibration ticks and a lock delay of 2304 ticks. Smaller values can be used for scaled-down runs.

Top module: `pll_init_seq`

## Requirements
- R1: While `porActive` is high, all three outputs are low and no tick advances the sequence. After it falls, the sequence begins at the initial wait.
- R2: In the initial wait, with `xtalUsed` high and `xtalAmpOk` low, the sequencer stays put and ignores every tick. With `xtalUsed` low, or once `xtalAmpOk` is high, it moves to the reference wait on the next cycle.
- R3: The reference wait consumes exactly REF_COUNT `refTick` pulses. `fbTick` pulses have no effect during it.
- R4: The feedback wait follows and consumes exactly FB_COUNT `fbTick` pulses. `refTick` pulses have no effect during it. `vcoCalActive` rises in the cycle after the last of them.
- R5: `vcoCalActive` stays high for exactly CAL_COUNT `refTick` pulses. `fbTick` pulses have no effect during it.
- R6: In the cycle after the last calibration tick, `outEnable` goes high and `vcoCalActive` goes low. The two are never high together.
- R7: `pllLocked` goes high in the cycle after LOCK_DELAY further `refTick` pulses have been counted with `outEnable` high. It then stays high, with `outEnable`, until a reset or power-down.
- R8: `rstPinN` low or `rstReg` high returns the sequencer to the initial wait on the next cycle, with all outputs low. It stays there while either is asserted, and every stage count restarts from zero afterwards. This holds also when it happens mid-calibration or during the lock wait.
- R9: `pwrDownN` low forces the power-down state on the next cycle, with all outputs low. This overrides every other input and state, and ticks are ignored while it is held.
- R10: On release from power-down, the sequencer passes through the initial wait and honours the crystal check of R2 before counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| porActive | input | 1 | Power-on-reset, high while supply is below threshold (asynchronous) |
| pwrDownN | input | 1 | Active-low full power-down |
| rstPinN | input | 1 | Active-low reset pin |
| rstReg | input | 1 | Register reset bit, active high |
| xtalUsed | input | 1 | High when the reference is a crystal |
| xtalAmpOk | input | 1 | Crystal swing is sufficient |
| refTick | input | 1 | One-cycle pulse per reference clock edge |
| fbTick | input | 1 | One-cycle pulse per feedback clock edge |
| vcoCalActive | output | 1 | High during the VCO calibration window |
| outEnable | output | 1 | Global output enable |
| pllLocked | output | 1 | Lock indicator |

## Verification
The bench builds the sequencer with REF_COUNT=8, FB_COUNT=6, CAL_COUNT=10 and LOCK_DELAY=5. This puts every stage boundary within a few dozen cycles, so the one-tick-early and one-tick-late edges of each stage are checked directly. The cases covered are back-to-back ticks, spaced ticks, and the wrong kind of tick interleaved. The small counts also allow aborts at chosen points: reset during calibration, reset in the lock wait, and power-down from the running state. Each abort is followed by a full rerun that would expose any count left over.

// File: rtl/pll_init_pkg.sv
package pll_init_pkg;

  typedef enum logic [2:0] {
    ST_PDN  = 3'd0,
    ST_XTAL = 3'd1,
    ST_REF  = 3'd2,
    ST_FB   = 3'd3,
    ST_CAL  = 3'd4,
    ST_LOCK = 3'd5,
    ST_RUN  = 3'd6
  } seqState_e;

  typedef enum logic [1:0] {
    LIM_REF  = 2'd0,
    LIM_FB   = 2'd1,
    LIM_CAL  = 2'd2,
    LIM_LOCK = 2'd3
  } limSel_e;

  // strobes from control to the stage counter
  typedef struct packed {
    logic    clr;
    logic    run;
    logic    useFb;
    limSel_e lim;
  } cntCtl_t;

endpackage

// File: rtl/pll_init_cnt.sv
module pll_init_cnt
  import pll_init_pkg::*;
#(
  parameter int REF_COUNT  = 65536,
  parameter int FB_COUNT   = 65536,
  parameter int CAL_COUNT  = 131072,
  parameter int LOCK_DELAY = 2304
) (
  input  logic    clk,
  input  logic    porActive,
  input  cntCtl_t ctl,
  input  logic    refTick,
  input  logic    fbTick,
  output logic    hitEnd
);

  localparam int M1   = (REF_COUNT > FB_COUNT) ? REF_COUNT : FB_COUNT;
  localparam int M2   = (CAL_COUNT > LOCK_DELAY) ? CAL_COUNT : LOCK_DELAY;
  localparam int MAXC = (M1 > M2) ? M1 : M2;
  localparam int CW   = $clog2(MAXC + 1);

  localparam logic [CW-1:0] REF_LAST  = CW'(REF_COUNT - 1);
  localparam logic [CW-1:0] FB_LAST   = CW'(FB_COUNT - 1);
  localparam logic [CW-1:0] CAL_LAST  = CW'(CAL_COUNT - 1);
  localparam logic [CW-1:0] LOCK_LAST = CW'(LOCK_DELAY - 1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] lastSel;
  logic          tick;

  always_comb begin
    case (ctl.lim)
      LIM_REF:  lastSel = REF_LAST;
      LIM_FB:   lastSel = FB_LAST;
      LIM_CAL:  lastSel = CAL_LAST;
      LIM_LOCK: lastSel = LOCK_LAST;
      default:  lastSel = REF_LAST;
    endcase
  end

  assign tick   = ctl.useFb ? fbTick : refTick;
  assign hitEnd = ctl.run && tick && (cnt == lastSel);

  always_ff @(posedge clk or posedge porActive) begin
    if (porActive)            cnt <= '0;
    else if (ctl.clr)         cnt <= '0;
    else if (ctl.run && tick) cnt <= cnt + 1'b1;
  end

  // R3 / R5: the stage count never runs past its limit
  a_r3_cnt_bound: assert property (@(posedge clk) disable iff (porActive)
    (ctl.run && !ctl.clr) |-> (cnt <= lastSel));

  // R3 / R5: feedback ticks do not move a reference-counted stage
  a_r3_ref_ignores_fb: assert property (@(posedge clk) disable iff (porActive)
    (ctl.run && !ctl.useFb && !ctl.clr && !refTick) |=> $stable(cnt));

  // R4: reference ticks do not move the feedback stage
  a_r4_fb_ignores_ref: assert property (@(posedge clk) disable iff (porActive)
    (ctl.run && ctl.useFb && !ctl.clr && !fbTick) |=> $stable(cnt));

endmodule

// File: rtl/pll_init_ctrl.sv
module pll_init_ctrl
  import pll_init_pkg::*;
(
  input  logic    clk,
  input  logic    porActive,
  input  logic    pwrDownN,
  input  logic    rstPinN,
  input  logic    rstReg,
  input  logic    xtalUsed,
  input  logic    xtalAmpOk,
  input  logic    hitEnd,
  output cntCtl_t ctl,
  output logic    vcoCalActive,
  output logic    outEnable,
  output logic    pllLocked
);

  seqState_e state, nxt;
  logic      rstAny;

  assign rstAny = !rstPinN || rstReg;

  always_comb begin
    nxt = state;
    if (!pwrDownN)   nxt = ST_PDN;
    else if (rstAny) nxt = ST_XTAL;
    else begin
      case (state)
        ST_PDN:  nxt = ST_XTAL;
        ST_XTAL: if (!xtalUsed || xtalAmpOk) nxt = ST_REF;
        ST_REF:  if (hitEnd) nxt = ST_FB;
        ST_FB:   if (hitEnd) nxt = ST_CAL;
        ST_CAL:  if (hitEnd) nxt = ST_LOCK;
        ST_LOCK: if (hitEnd) nxt = ST_RUN;
        ST_RUN:  nxt = ST_RUN;
        default: nxt = ST_XTAL;
      endcase
    end
  end

  always_ff @(posedge clk or posedge porActive) begin
    if (porActive) state <= ST_XTAL;
    else           state <= nxt;
  end

  always_comb begin
    ctl.clr   = (nxt != state);
    ctl.run   = (state == ST_REF) || (state == ST_FB) ||
                (state == ST_CAL) || (state == ST_LOCK);
    ctl.useFb = (state == ST_FB);
    case (state)
      ST_FB:   ctl.lim = LIM_FB;
      ST_CAL:  ctl.lim = LIM_CAL;
      ST_LOCK: ctl.lim = LIM_LOCK;
      default: ctl.lim = LIM_REF;
    endcase
  end

  assign vcoCalActive = (state == ST_CAL);
  assign outEnable    = (state == ST_LOCK) || (state == ST_RUN);
  assign pllLocked    = (state == ST_RUN);

  // R2: no advance while the crystal has too little swing
  a_r2_xtal_hold: assert property (@(posedge clk) disable iff (porActive)
    (state == ST_XTAL && pwrDownN && !rstAny && xtalUsed && !xtalAmpOk)
    |=> (state == ST_XTAL));

  // R6: the calibration-ending tick turns outputs on at once
  a_r6_enable_at_cal_end: assert property (@(posedge clk) disable iff (porActive)
    (state == ST_CAL && hitEnd && pwrDownN && !rstAny)
    |=> (outEnable && !vcoCalActive));

  // R7: lock only rises out of the lock wait
  a_r7_lock_from_wait: assert property (@(posedge clk) disable iff (porActive)
    $rose(pllLocked) |-> ($past(state) == ST_LOCK));

  // R8: either reset source restarts the sequence with outputs off
  a_r8_reset_returns: assert property (@(posedge clk) disable iff (porActive)
    (pwrDownN && rstAny)
    |=> (state == ST_XTAL && !outEnable && !vcoCalActive && !pllLocked));

  // R9: power-down wins over everything
  a_r9_pdn_override: assert property (@(posedge clk) disable iff (porActive)
    !pwrDownN |=> (state == ST_PDN && !outEnable && !vcoCalActive && !pllLocked));

  // R10: leaving power-down always goes through the initial wait
  a_r10_pdn_exit: assert property (@(posedge clk) disable iff (porActive)
    (state == ST_PDN && pwrDownN) |=> (state == ST_XTAL));

endmodule

// File: rtl/pll_init_seq.sv
module pll_init_seq
  import pll_init_pkg::*;
#(
  parameter int REF_COUNT  = 65536,
  parameter int FB_COUNT   = 65536,
  parameter int CAL_COUNT  = 131072,
  parameter int LOCK_DELAY = 2304
) (
  input  logic clk,
  input  logic porActive,
  input  logic pwrDownN,
  input  logic rstPinN,
  input  logic rstReg,
  input  logic xtalUsed,
  input  logic xtalAmpOk,
  input  logic refTick,
  input  logic fbTick,
  output logic vcoCalActive,
  output logic outEnable,
  output logic pllLocked
);

  cntCtl_t ctl;
  logic    hitEnd;

  pll_init_ctrl u_ctrl (
    .clk          (clk),
    .porActive    (porActive),
    .pwrDownN     (pwrDownN),
    .rstPinN      (rstPinN),
    .rstReg       (rstReg),
    .xtalUsed     (xtalUsed),
    .xtalAmpOk    (xtalAmpOk),
    .hitEnd       (hitEnd),
    .ctl          (ctl),
    .vcoCalActive (vcoCalActive),
    .outEnable    (outEnable),
    .pllLocked    (pllLocked)
  );

  pll_init_cnt #(
    .REF_COUNT  (REF_COUNT),
    .FB_COUNT   (FB_COUNT),
    .CAL_COUNT  (CAL_COUNT),
    .LOCK_DELAY (LOCK_DELAY)
  ) u_cnt (
    .clk       (clk),
    .porActive (porActive),
    .ctl       (ctl),
    .refTick   (refTick),
    .fbTick    (fbTick),
    .hitEnd    (hitEnd)
  );

  // R6: calibration and output enable are never both high
  a_r6_exclusive: assert property (@(posedge clk) disable iff (porActive)
    $onehot0({vcoCalActive, outEnable}));

endmodule

// File: tb/pll_init_seq_bench.sv
`timescale 1ns/100ps
module pll_init_seq_bench;

  localparam int REF_N  = 8;
  localparam int FB_N   = 6;
  localparam int CAL_N  = 10;
  localparam int LOCK_N = 5;

  // vector: {xtalUsed, noise, gap[3:0]}
  localparam logic [5:0] VECS [4] = '{
    6'b0_0_0001,
    6'b0_1_0010,
    6'b1_1_0001,
    6'b0_1_0011
  };

  logic clk = 1'b0;
  logic porActive = 1'b1;
  logic pwrDownN = 1'b1;
  logic rstPinN = 1'b1;
  logic rstReg = 1'b0;
  logic xtalUsed = 1'b0;
  logic xtalAmpOk = 1'b0;
  logic refTick = 1'b0;
  logic fbTick = 1'b0;
  logic vcoCalActive, outEnable, pllLocked;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pll_init_seq #(
    .REF_COUNT  (REF_N),
    .FB_COUNT   (FB_N),
    .CAL_COUNT  (CAL_N),
    .LOCK_DELAY (LOCK_N)
  ) u_pll_init_seq (
    .clk          (clk),
    .porActive    (porActive),
    .pwrDownN     (pwrDownN),
    .rstPinN      (rstPinN),
    .rstReg       (rstReg),
    .xtalUsed     (xtalUsed),
    .xtalAmpOk    (xtalAmpOk),
    .refTick      (refTick),
    .fbTick       (fbTick),
    .vcoCalActive (vcoCalActive),
    .outEnable    (outEnable),
    .pllLocked    (pllLocked)
  );

  // expected is {vcoCalActive, outEnable, pllLocked}
  task automatic chk(input string tag, input logic [2:0] exp);
    logic [2:0] act;
    act = {vcoCalActive, outEnable, pllLocked};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got {cal,oe,lock}=%b expected %b", tag, act, exp);
    end
  endtask

  task automatic pulse(input bit isFb, input int gap);
    @(negedge clk);
    if (isFb) fbTick = 1'b1;
    else      refTick = 1'b1;
    @(negedge clk);
    refTick = 1'b0;
    fbTick  = 1'b0;
    repeat (gap - 1) @(negedge clk);
  endtask

  // stopAt: 0 full run, 1 stop once calibrating, 2 stop once enabled
  task automatic runSeq(input int gap, input bit noise, input int stopAt, input string tag);
    for (int i = 0; i < REF_N; i++) begin
      if (noise) pulse(1'b1, gap);
      pulse(1'b0, gap);
      if (i == REF_N - 2) chk({"R3 ref wait one tick short ", tag}, 3'b000);
    end
    chk({"R3 ref wait done, no outputs ", tag}, 3'b000);
    for (int i = 0; i < FB_N; i++) begin
      if (noise) pulse(1'b0, gap);
      pulse(1'b1, gap);
      if (i == FB_N - 2) chk({"R4 fb wait one tick short ", tag}, 3'b000);
    end
    chk({"R4 calibration starts ", tag}, 3'b100);
    if (stopAt == 1) return;
    for (int i = 0; i < CAL_N; i++) begin
      if (noise) pulse(1'b1, gap);
      pulse(1'b0, gap);
      if (i == CAL_N - 2) chk({"R5 calibration one tick short ", tag}, 3'b100);
    end
    chk({"R6 outputs on at calibration end ", tag}, 3'b010);
    if (stopAt == 2) return;
    for (int i = 0; i < LOCK_N; i++) begin
      if (noise) pulse(1'b1, gap);
      pulse(1'b0, gap);
      if (i == LOCK_N - 2) chk({"R7 lock one tick short ", tag}, 3'b010);
    end
    chk({"R7 locked ", tag}, 3'b011);
    pulse(1'b0, 1);
    pulse(1'b1, 1);
    chk({"R7 lock stays ", tag}, 3'b011);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 outputs low under power-on-reset", 3'b000);
    pulse(1'b0, 1);
    pulse(1'b1, 1);
    chk("R1 ticks ignored under power-on-reset", 3'b000);
    porActive = 1'b0;

    // vector table
    for (int v = 0; v < 4; v++) begin
      logic [5:0] vec;
      int gap;
      bit noise;
      vec   = VECS[v];
      gap   = int'(vec[3:0]);
      noise = vec[4];
      xtalUsed  = vec[5];
      xtalAmpOk = !vec[5];
      @(negedge clk);
      rstReg = 1'b1;
      @(negedge clk);
      chk("R8 register reset clears outputs", 3'b000);
      rstReg = 1'b0;
      repeat (2) @(negedge clk);
      if (vec[5]) begin
        for (int k = 0; k < REF_N; k++) begin
          pulse(1'b0, 1);
          pulse(1'b1, 1);
        end
        chk("R2 held while crystal swing low", 3'b000);
        xtalAmpOk = 1'b1;
        repeat (2) @(negedge clk);
      end
      runSeq(gap, noise, 0, $sformatf("vec%0d", v));
    end

    // reset pin during calibration
    xtalUsed = 1'b0;
    xtalAmpOk = 1'b0;
    @(negedge clk); rstReg = 1'b1;
    @(negedge clk); rstReg = 1'b0;
    repeat (2) @(negedge clk);
    runSeq(1, 1'b0, 1, "pre-abort");
    rstPinN = 1'b0;
    @(negedge clk);
    chk("R8 reset pin aborts calibration", 3'b000);
    pulse(1'b0, 1); pulse(1'b0, 1); pulse(1'b1, 1);
    chk("R8 held while reset pin low", 3'b000);
    rstPinN = 1'b1;
    repeat (2) @(negedge clk);
    runSeq(1, 1'b1, 0, "R8 rerun after cal abort");

    // register reset during lock wait
    @(negedge clk); rstReg = 1'b1;
    @(negedge clk); rstReg = 1'b0;
    repeat (2) @(negedge clk);
    runSeq(2, 1'b0, 2, "pre-lock-abort");
    pulse(1'b0, 1);
    rstReg = 1'b1;
    @(negedge clk);
    chk("R8 register reset aborts lock wait", 3'b000);
    rstReg = 1'b0;
    repeat (2) @(negedge clk);
    runSeq(1, 1'b0, 0, "R8 rerun after lock abort");

    // power-down from running, with reset pin also low
    pwrDownN = 1'b0;
    @(negedge clk);
    chk("R9 power-down forces outputs low", 3'b000);
    rstPinN = 1'b0;
    pulse(1'b0, 1); pulse(1'b1, 1);
    rstPinN = 1'b1;
    for (int k = 0; k < REF_N + CAL_N; k++) begin
      pulse(1'b0, 1);
      pulse(1'b1, 1);
    end
    chk("R9 ticks ignored in power-down", 3'b000);
    xtalUsed  = 1'b1;
    xtalAmpOk = 1'b0;
    pwrDownN  = 1'b1;
    repeat (2) @(negedge clk);
    for (int k = 0; k < REF_N; k++) begin
      pulse(1'b0, 1);
      pulse(1'b1, 1);
    end
    chk("R10 crystal check after power-down exit", 3'b000);
    xtalAmpOk = 1'b1;
    repeat (2) @(negedge clk);
    runSeq(1, 1'b1, 0, "R10 rerun after power-down");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: run did not complete, got timeout expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule